// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the completion events of a bank of DMA channels and turns them into one level-sensitive interrupt line. Each channel raises single-cycle pulses when half of a transfer is done, when a packet is done and when its whole queue is done. The block latches each pulse into a pending bit, but only if software has enabled that event. Software reads the pending bits through a small register port and acknowledges them by writing ones back.

Each channel has a 4-bit field, and eight channels share one 32-bit register. The channel count is a parameter that may be 16 or 8. A read-only status word shows which channels are busy. Register reads are combinational on the address. Writes take effect at the clock edge on which `reg_we` is sampled high.

Top module: `irq_agg`

## Requirements
- R1: Channel n maps to bank n/8 at field base 4×(n mod 8). Within a field, bit 0 is half-done (`ev_half`), bit 1 is packet-done (`ev_pkt`) and bit 2 is queue-done (`ev_queue`).
- R2: The enable words are read/write at offset 0x00 (channels 0–7) and offset 0x04 (channels 8–15). Bit 3 of every field reads as zero whatever is written there.
- R3: A pending bit sets on an event pulse only if the matching enable bit held 1 at the clock edge that samples the pulse. An event whose enable bit is 0 leaves the pending bit at 0.
- R4: The pending words are at offset 0x10 (channels 0–7) and offset 0x14 (channels 8–15). Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R5: If an enabled event and a write-1 clear hit the same pending bit at the same edge, the bit stays 1.
- R6: `irq` is high exactly when some pending bit has its enable bit set. It stays high, with no new events, until those bits are cleared.
- R7: Writing 0 to both enable words drops `irq` at once. Bits that are already pending are kept, and later events no longer latch.
- R8: Offset 0x30 reads the busy status: bit n equals `ch_busy[n]` and the upper bits are 0.
- R9: With NUM_CH=8, offsets 0x04 and 0x14 read 0 and ignore writes, while offsets 0x00 and 0x10 work as for 16 channels.
- R10: After reset, all enable and pending bits are 0 and `irq` is low.
- R11: Offsets that are not mapped read 0. Writes to them, or to the status word, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_half | input | NUM_CH | Half-done pulse per channel |
| ev_pkt | input | NUM_CH | Packet-done pulse per channel |
| ev_queue | input | NUM_CH | Queue-done pulse per channel |
| ch_busy | input | NUM_CH | Busy level per channel, shown at 0x30 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
A pending bit that latches while its enable is 0, or that drops without a matching write-1, shows up in the pending word on the next read. It also shows on `irq` one edge after the event or write that caused it. A lost same-edge set shows as a cleared bit, and `irq` falling early, right after that edge. A mis-packed field puts a channel's event at the wrong bit position, and the first read of the pending word reveals it. Reserved bits leaking through, or a missing second bank in the 8-channel variant, show as non-zero read data on the first access.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int CH_PER_REG = 8;
  localparam int FIELD_W    = 4;
  localparam int REG_W      = CH_PER_REG * FIELD_W;
  localparam int EV_USED    = 3;
  localparam logic [7:0] OFF_STATUS = 8'h30;

  typedef struct packed {
    logic en_we;
    logic pd_we;
  } bank_wr_t;

  function automatic logic [7:0] en_off(input int b);
    return 8'(4 * b);
  endfunction

  function automatic logic [7:0] pd_off(input int b);
    return 8'(16 + 4 * b);
  endfunction

  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < CH_PER_REG; c++)
      for (int k = 0; k < EV_USED; k++)
        m[c*FIELD_W + k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_agg_dec.sv
module irq_agg_dec
  import irq_agg_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  output bank_wr_t [NBANK-1:0]  wr
);
  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    always_comb begin
      wr[b].en_we = reg_we && (reg_addr == ADDR_W'(en_off(b)));
      wr[b].pd_we = reg_we && (reg_addr == ADDR_W'(pd_off(b)));
    end
  end
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ev,
  input  logic             en_we,
  input  logic             pd_we,
  input  logic [31:0]      wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] pd_q,
  output logic             irq
);
  localparam logic [REG_W-1:0] LIVE = live_mask();

  logic [REG_W-1:0] en_d, pd_d, pd_set, pd_clr;
  logic             en_ce, pd_ce;

  always_comb begin
    en_ce  = en_we;
    en_d   = wdata[REG_W-1:0] & LIVE;
    pd_set = ev & en_q & LIVE;
    pd_clr = pd_we ? wdata[REG_W-1:0] : '0;
    pd_d   = (pd_q & ~pd_clr) | pd_set;
    pd_ce  = pd_we | (|pd_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      pd_q <= '0;
    end else begin
      if (en_ce) en_q <= en_d;
      if (pd_ce) pd_q <= pd_d;
    end
  end

  assign irq = |(pd_q & en_q);
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int NBANK  = 2,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [NBANK*REG_W-1:0] en_flat,
  input  logic [NBANK*REG_W-1:0] pd_flat,
  input  logic [NUM_CH-1:0]      ch_busy,
  output logic [31:0]            reg_rdata
);
  logic [2*REG_W-1:0] en_pad, pd_pad;

  assign en_pad = (2*REG_W)'(en_flat);
  assign pd_pad = (2*REG_W)'(pd_flat);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(en_off(0)))      reg_rdata = en_pad[REG_W-1:0];
    else if (reg_addr == ADDR_W'(en_off(1))) reg_rdata = en_pad[2*REG_W-1:REG_W];
    else if (reg_addr == ADDR_W'(pd_off(0))) reg_rdata = pd_pad[REG_W-1:0];
    else if (reg_addr == ADDR_W'(pd_off(1))) reg_rdata = pd_pad[2*REG_W-1:REG_W];
    else if (reg_addr == ADDR_W'(OFF_STATUS)) reg_rdata = 32'(ch_busy);
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_half,
  input  logic [NUM_CH-1:0] ev_pkt,
  input  logic [NUM_CH-1:0] ev_queue,
  input  logic [NUM_CH-1:0] ch_busy,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int NBANK  = NUM_CH / CH_PER_REG;
  localparam int FLAT_W = NBANK * REG_W;

  logic [1:0]           rst_pipe;
  logic                 rst_n_sync;
  logic [FLAT_W-1:0]    ev_flat, en_flat, pd_flat;
  logic [NBANK-1:0]     bank_irq;
  bank_wr_t [NBANK-1:0] wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
    assign ev_flat[c*FIELD_W +: FIELD_W] = {1'b0, ev_queue[c], ev_pkt[c], ev_half[c]};
  end

  irq_agg_dec #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_dec (
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .wr      (wr)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irq_agg_bank u_bank (
      .clk  (clk),
      .rst_n(rst_n_sync),
      .ev   (ev_flat[b*REG_W +: REG_W]),
      .en_we(wr[b].en_we),
      .pd_we(wr[b].pd_we),
      .wdata(reg_wdata),
      .en_q (en_flat[b*REG_W +: REG_W]),
      .pd_q (pd_flat[b*REG_W +: REG_W]),
      .irq  (bank_irq[b])
    );
  end

  irq_agg_rdmux #(.NUM_CH(NUM_CH), .NBANK(NBANK), .ADDR_W(ADDR_W)) u_rd (
    .reg_addr (reg_addr),
    .en_flat  (en_flat),
    .pd_flat  (pd_flat),
    .ch_busy  (ch_busy),
    .reg_rdata(reg_rdata)
  );

  assign irq = |bank_irq;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_CH-1:0]                 ev_half,
  input logic [NUM_CH-1:0]                 ev_pkt,
  input logic [NUM_CH-1:0]                 ev_queue,
  input logic [NUM_CH-1:0]                 ch_busy,
  input logic                              reg_we,
  input logic [ADDR_W-1:0]                 reg_addr,
  input logic [31:0]                       reg_wdata,
  input logic [31:0]                       reg_rdata,
  input logic                              irq,
  input logic [NUM_CH/CH_PER_REG*REG_W-1:0] en_flat,
  input logic [NUM_CH/CH_PER_REG*REG_W-1:0] pd_flat
);
  localparam int NBANK  = NUM_CH / CH_PER_REG;
  localparam int FLAT_W = NBANK * REG_W;

  logic [FLAT_W-1:0] evv, clr, live;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ev
    assign evv[c*FIELD_W +: FIELD_W] = {1'b0, ev_queue[c], ev_pkt[c], ev_half[c]};
  end
  for (genvar b = 0; b < NBANK; b++) begin : g_clr
    assign clr[b*REG_W +: REG_W]  = (reg_we && reg_addr == ADDR_W'(pd_off(b))) ? reg_wdata : '0;
    assign live[b*REG_W +: REG_W] = live_mask();
  end

  p_set_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pd_flat & ~$past(pd_flat)) & ~$past(en_flat & evv)) == '0);

  p_clear_needs_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pd_flat & $past(pd_flat)) & ~$past(clr)) == '0);

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_flat & evv & live) & ~pd_flat) == '0);

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(pd_flat & en_flat)));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_flat | pd_flat) & ~live) == '0);

  p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_STATUS)) |-> (reg_rdata == 32'(ch_busy)));
endmodule

bind irq_agg irq_agg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_half  (ev_half),
  .ev_pkt   (ev_pkt),
  .ev_queue (ev_queue),
  .ch_busy  (ch_busy),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .irq      (irq),
  .en_flat  (en_flat),
  .pd_flat  (pd_flat)
);

// File: tb/tb_irq_agg.sv
module tb_irq_agg;
  localparam int CLK_P = 10;

  logic        clk, rst_n, reg_we, irq, irq8;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, rdata, rdata8;
  logic [15:0] ev_half, ev_pkt, ev_queue, ch_busy;
  int chk_n = 0, err_n = 0;

  irq_agg #(.NUM_CH(16), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .ev_half(ev_half), .ev_pkt(ev_pkt), .ev_queue(ev_queue),
    .ch_busy(ch_busy), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq(irq));

  irq_agg #(.NUM_CH(8), .ADDR_W(8)) dut8 (
    .clk(clk), .rst_n(rst_n), .ev_half(ev_half[7:0]), .ev_pkt(ev_pkt[7:0]),
    .ev_queue(ev_queue[7:0]), .ch_busy(ch_busy[7:0]), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata8), .irq(irq8));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [15:0] half;
    logic [15:0] pkt;
    logic [15:0] que;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic        eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000, 8'h00, 32'h7777_7777, 1'b0, 4'd2}, // R2 reserved bits masked
    '{1'b1, 8'h04, 32'h0000_0124, 16'h0000, 16'h0000, 16'h0000, 8'h04, 32'h0000_0124, 1'b0, 4'd2}, // R2
    '{1'b0, 8'h00, 32'h0,         16'h0001, 16'h0000, 16'h0000, 8'h10, 32'h0000_0001, 1'b1, 4'd1}, // R1 ch0 half
    '{1'b0, 8'h00, 32'h0,         16'h0000, 16'h0020, 16'h0000, 8'h10, 32'h0020_0001, 1'b1, 4'd1}, // R1 ch5 pkt
    '{1'b0, 8'h00, 32'h0,         16'h0000, 16'h0000, 16'h0200, 8'h14, 32'h0000_0000, 1'b1, 4'd3}, // R3 ch9 queue masked
    '{1'b0, 8'h00, 32'h0,         16'h0000, 16'h0000, 16'h0100, 8'h14, 32'h0000_0004, 1'b1, 4'd1}, // R1 ch8 queue
    '{1'b0, 8'h00, 32'h0,         16'h0400, 16'h0000, 16'h0000, 8'h14, 32'h0000_0104, 1'b1, 4'd1}, // R1 ch10 half
    '{1'b1, 8'h10, 32'h0000_0000, 16'h0000, 16'h0000, 16'h0000, 8'h10, 32'h0020_0001, 1'b1, 4'd4}, // R4 zeros no effect
    '{1'b1, 8'h10, 32'h0000_0001, 16'h0000, 16'h0000, 16'h0000, 8'h10, 32'h0020_0000, 1'b1, 4'd4}, // R4 one bit
    '{1'b1, 8'h10, 32'h0020_0000, 16'h0000, 16'h0000, 16'h0000, 8'h10, 32'h0000_0000, 1'b1, 4'd6}, // R6 bank1 holds irq
    '{1'b1, 8'h14, 32'h0000_0104, 16'h0000, 16'h0000, 16'h0000, 8'h14, 32'h0000_0000, 1'b0, 4'd6}, // R6 all clear
    '{1'b1, 8'h30, 32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000, 8'h00, 32'h7777_7777, 1'b0, 4'd11}, // R11 status write
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000, 8'h08, 32'h0000_0000, 1'b0, 4'd11}, // R11 unmapped
    '{1'b1, 8'h00, 32'h0000_0000, 16'h0000, 16'h0000, 16'h0000, 8'h00, 32'h0000_0000, 1'b0, 4'd7}, // R7
    '{1'b1, 8'h04, 32'h0000_0000, 16'h0000, 16'h0000, 16'h0000, 8'h04, 32'h0000_0000, 1'b0, 4'd7}, // R7
    '{1'b0, 8'h00, 32'h0,         16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h10, 32'h0000_0000, 1'b0, 4'd7}  // R7 masked events
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk_n++;
    if (act !== exp) begin
      err_n++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] h, input logic [15:0] p, input logic [15:0] q);
    @(negedge clk);
    ev_half = h; ev_pkt = p; ev_queue = q;
    @(negedge clk);
    ev_half = '0; ev_pkt = '0; ev_queue = '0;
  endtask

  task automatic rd16(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic rd8(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    check(tag, rdata8, exp);
  endtask

  initial begin
    #(CLK_P * 50000);
    err_n++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", chk_n, err_n);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ev_half = '0; ev_pkt = '0; ev_queue = '0; ch_busy = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd16(8'h00, 32'h0, "R10 en0");
    rd16(8'h04, 32'h0, "R10 en1");
    rd16(8'h10, 32'h0, "R10 pd0");
    rd16(8'h14, 32'h0, "R10 pd1");
    check("R10 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_we = VEC[i].wr; reg_addr = VEC[i].waddr; reg_wdata = VEC[i].wdata;
      ev_half = VEC[i].half; ev_pkt = VEC[i].pkt; ev_queue = VEC[i].que;
      @(negedge clk);
      reg_we = 1'b0; ev_half = '0; ev_pkt = '0; ev_queue = '0;
      reg_addr = VEC[i].raddr; #1;
      check($sformatf("R%0d vec%0d data", VEC[i].req, i), rdata, VEC[i].exp);
      check($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'b0, irq}, {31'b0, VEC[i].eirq});
    end

    // R5 set wins over same-edge clear
    do_write(8'h00, 32'h0000_0001);
    pulse(16'h0001, 16'h0, 16'h0);
    rd16(8'h10, 32'h0000_0001, "R3 enabled latch");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h0000_0001; ev_half = 16'h0001;
    @(negedge clk);
    reg_we = 1'b0; ev_half = '0;
    rd16(8'h10, 32'h0000_0001, "R5 event wins");
    do_write(8'h10, 32'h0000_0001);
    rd16(8'h10, 32'h0, "R4 clear");

    // R6 level held, R7 masking keeps pending
    pulse(16'h0001, 16'h0, 16'h0);
    repeat (5) @(negedge clk);
    check("R6 irq held", {31'b0, irq}, 32'h1);
    do_write(8'h00, 32'h0);
    do_write(8'h04, 32'h0);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    rd16(8'h10, 32'h0000_0001, "R7 pending kept");
    do_write(8'h00, 32'h0000_0001);
    check("R6 irq re-enabled", {31'b0, irq}, 32'h1);
    do_write(8'h10, 32'hFFFF_FFFF);
    check("R6 irq cleared", {31'b0, irq}, 32'h0);

    // R8 busy status
    ch_busy = 16'hA5C3;
    rd16(8'h30, 32'h0000_A5C3, "R8 status16");
    rd8(8'h30, 32'h0000_00C3, "R8 status8");
    rd16(8'h34, 32'h0, "R11 unmapped 0x34");

    // R9 eight-channel variant
    do_write(8'h04, 32'hFFFF_FFFF);
    rd8(8'h04, 32'h0, "R9 en1 absent");
    do_write(8'h00, 32'hFFFF_FFFF);
    rd8(8'h00, 32'h7777_7777, "R9 en0 present");
    pulse(16'h0000, 16'h0080, 16'h0000);
    rd8(8'h10, 32'h2000_0000, "R9 pd0 ch7 pkt");
    rd8(8'h14, 32'h0, "R9 pd1 absent");
    check("R9 irq8", {31'b0, irq8}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", chk_n, err_n);
    $finish;
  end
endmodule